// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the configurable AND/OR plane of a small programmable logic device. Fourteen dedicated inputs and twelve macrocell feedback signals form 26 array signals. Each signal is offered to the array in true and complement form, which gives 52 literal columns. A stored connection pattern of 150 rows by 52 columns defines the product terms. Fixed OR gates add an uneven number of terms for each of the twelve sum outputs. Four kinds of row are dedicated: one output-enable term per output, one asynchronous-reset term and one synchronous-preset term. The array outputs are purely combinational from the input and feedback vectors.

The pattern is written one bit at a time through a valid/ready load stream. It is read back the same way through a valid/ready readback stream. Both streams walk rows from 0 upward, with columns in ascending order inside a row. Back-pressure works the usual way. On the load side a bit is taken only in a cycle where `ld_valid` and `ld_ready` are both high. On the readback side a bit is consumed only in a cycle where `rb_valid` and `rb_ready` are both high, and `rb_bit` holds its value until that happens. Three single-cycle command pins, all plain, control the rest:
- rewind puts both stream pointers back to row 0, column 0;
- lock sets a sticky security bit;
- erase disconnects every cell and clears the lock.

Top module: `pla_sop_array`

## Requirements
- R1: Signal s is `din[s]` for s < 14 and `fb[s-14]` for s from 14 to 25. Column 2s holds the true form of signal s and column 2s+1 its complement. A cell value of 1 means connected. A product term is the AND of every literal whose cell in that row is connected.
- R2: A row with no connected cell evaluates to 1.
- R3: A row that connects both the true and the complement literal of any one signal evaluates to 0 for every input vector.
- R4: Rows 0 to 135 are sum terms, assigned to the outputs in consecutive blocks. The block sizes are 8, 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 and 8 for `sum_out[0]` to `sum_out[11]`. Each output is the OR of its block.
- R5: Row 136+o drives `oe_term[o]`, row 148 drives `ar_term` and row 149 drives `sp_term`.
- R6: The load stream has the following behaviour:
  - Within each group of 52 accepted bits, the k-th bit lands in column k.
  - Groups fill rows 0, 1, 2 and so on.
  - `ld_ready` is high while fewer than 150 rows have been loaded.
  - A rewind restarts the stream at row 0, column 0 and drops any partial row.
- R7: `rb_valid` is high while readback rows remain. `rb_bit` shows the cells in the same row and column order as the load stream. The stream advances only on accepted transfers, and `rb_valid` goes low once all 7800 bits have been read.
- R8: While locked:
  - Readback shows every cell as 0.
  - `ld_ready` is low, so offered bits are ignored.
  - The array function is unchanged.
- R9: The lock is cleared only by erase; rewind and further lock commands leave it set. Erase disconnects all cells and resets both pointers. When erase and lock come in the same cycle, erase wins.
- R10: After reset, every cell is disconnected, the lock is clear and both pointers are at zero. As a result every array output is 1, `ld_ready` and `rb_valid` are 1, and `rb_bit` is 0.
- R11: The array outputs follow `din` and `fb` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration logic |
| rst_n | input | 1 | Active-low synchronous reset; same effect as erase |
| din | input | 14 | Dedicated array inputs |
| fb | input | 12 | Macrocell feedback inputs |
| sum_out | output | 12 | OR of each output's product-term block |
| oe_term | output | 12 | Output-enable product term per output |
| ar_term | output | 1 | Shared asynchronous-reset product term |
| sp_term | output | 1 | Shared synchronous-preset product term |
| cmd_erase | input | 1 | Disconnect all cells, clear lock, reset pointers |
| cmd_lock | input | 1 | Set the sticky security bit |
| cmd_rewind | input | 1 | Return both stream pointers to row 0, column 0 |
| ld_valid | input | 1 | Load stream bit is valid |
| ld_ready | output | 1 | Load stream can accept a bit |
| ld_bit | input | 1 | Load stream data bit |
| rb_valid | output | 1 | Readback bit is valid |
| rb_ready | input | 1 | Consumer accepts the readback bit |
| rb_bit | output | 1 | Readback data bit |

## Verification
The bench targets the block boundaries and the stream behaviour:
- One pattern connects each row to exactly one true literal, chosen by row number, and the bench walks a single one across all 26 signals. A design that shifts any block boundary by one row would move a term into the neighbouring output and flip that output's bit.
- Pseudo-random patterns include empty rows and rows with conflicting literals. A design that inverts empty-row semantics or lets a conflicting row pass would show up in the sum and enable outputs.
- Loads run with gaps in `ld_valid`, and readback runs with gaps in `rb_ready`. A partial row is abandoned by a rewind before the next load. A design that takes bits without a handshake, or keeps a stale column count, would read back a misaligned pattern.
- After a lock, the bench offers load bits, rewinds and reads back. A lock that leaks the pattern, accepts writes or is cleared by rewind is reported. So is an erase that leaves cells connected or the lock set.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Number of product terms summed by output o: the count rises from the
  // two ends of the output row towards the middle.
  function automatic int out_terms(int o, int n_out, int base_t, int step_t);
    int k;
    k = (o < n_out / 2) ? o : (n_out - 1 - o);
    return (k < 2) ? base_t : base_t + step_t * (k - 1);
  endfunction

  // First sum row of output o (rows are packed in output order).
  function automatic int out_base(int o, int n_out, int base_t, int step_t);
    int acc;
    acc = 0;
    for (int j = 0; j < o; j++) acc += out_terms(j, n_out, base_t, step_t);
    return acc;
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int ROWS = 150,
  parameter int COLS = 52
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_erase,
  input  logic                       cmd_lock,
  input  logic                       cmd_rewind,
  input  logic                       ld_valid,
  output logic                       ld_ready,
  input  logic                       ld_bit,
  output logic                       rb_valid,
  input  logic                       rb_ready,
  output logic                       rb_bit,
  output logic [ROWS-1:0][COLS-1:0]  pat
);
  localparam int RW = $clog2(ROWS + 1);
  localparam int CW = $clog2(COLS);
  localparam logic [RW-1:0] ROW_END = RW'(ROWS);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  logic [ROWS-1:0][COLS-1:0] pat_q;
  logic [COLS-1:0]           shreg;
  logic [RW-1:0]             ld_row, rb_row;
  logic [CW-1:0]             ld_col, rb_col;
  logic                      locked;
  logic                      ld_fire, rb_fire;

  assign ld_ready = !locked && (ld_row < ROW_END);
  assign rb_valid = (rb_row < ROW_END);
  assign rb_bit   = rb_valid && !locked && pat_q[rb_row][rb_col];
  assign ld_fire  = ld_valid && ld_ready;
  assign rb_fire  = rb_valid && rb_ready;
  assign pat      = pat_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cmd_erase) begin
      pat_q  <= '0;
      shreg  <= '0;
      ld_row <= '0;
      ld_col <= '0;
      rb_row <= '0;
      rb_col <= '0;
      locked <= 1'b0;
    end else begin
      if (cmd_rewind) begin
        ld_row <= '0;
        ld_col <= '0;
        rb_row <= '0;
        rb_col <= '0;
      end else begin
        if (ld_fire) begin
          if (ld_col == COL_LAST) begin
            pat_q[ld_row] <= {ld_bit, shreg[COLS-1:1]};
            ld_col <= '0;
            ld_row <= ld_row + 1'b1;
          end else begin
            shreg  <= {ld_bit, shreg[COLS-1:1]};
            ld_col <= ld_col + 1'b1;
          end
        end
        if (rb_fire) begin
          if (rb_col == COL_LAST) begin
            rb_col <= '0;
            rb_row <= rb_row + 1'b1;
          end else begin
            rb_col <= rb_col + 1'b1;
          end
        end
      end
      if (cmd_lock) locked <= 1'b1;
    end
  end

  assert_erase_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_erase |=> (pat == '0) && ld_ready && rb_valid);

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !cmd_erase) |=> locked);

  assert_lock_blanks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lock && !cmd_erase) |=> (!rb_bit && !ld_ready));

  assert_row_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && ld_col == COL_LAST && !cmd_rewind && !cmd_erase)
      |=> (ld_row == $past(ld_row) + 1'b1) && (ld_col == '0));

  assert_rb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready && !cmd_rewind && !cmd_erase)
      |=> rb_valid && $stable(rb_row) && $stable(rb_col));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_SIG = 26,
  parameter int ROWS  = 150,
  localparam int COLS = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]           sig,
  input  logic [ROWS-1:0][COLS-1:0]  pat,
  output logic [ROWS-1:0]            term
);
  logic [COLS-1:0] lit;

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit[2*s]     = sig[s];
    assign lit[2*s + 1] = ~sig[s];
  end

  // An unconnected cell contributes a 1; a connected one passes its literal.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign term[r] = &(~pat[r] | lit);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_OUT  = 12,
  parameter int BASE_T = 8,
  parameter int STEP_T = 2,
  localparam int SUM_ROWS = pla_pkg::out_base(N_OUT, N_OUT, BASE_T, STEP_T)
) (
  input  logic [SUM_ROWS-1:0] term,
  output logic [N_OUT-1:0]    sum_out
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int B = pla_pkg::out_base(o, N_OUT, BASE_T, STEP_T);
    localparam int C = pla_pkg::out_terms(o, N_OUT, BASE_T, STEP_T);
    assign sum_out[o] = |term[B +: C];
  end

endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
  parameter int N_IN   = 14,
  parameter int N_OUT  = 12,
  parameter int BASE_T = 8,
  parameter int STEP_T = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   din,
  input  logic [N_OUT-1:0]  fb,
  output logic [N_OUT-1:0]  sum_out,
  output logic [N_OUT-1:0]  oe_term,
  output logic              ar_term,
  output logic              sp_term,
  input  logic              cmd_erase,
  input  logic              cmd_lock,
  input  logic              cmd_rewind,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_bit,
  output logic              rb_valid,
  input  logic              rb_ready,
  output logic              rb_bit
);
  localparam int N_SIG    = N_IN + N_OUT;
  localparam int COLS     = 2 * N_SIG;
  localparam int SUM_ROWS = pla_pkg::out_base(N_OUT, N_OUT, BASE_T, STEP_T);
  localparam int OE_ROW0  = SUM_ROWS;
  localparam int AR_ROW   = OE_ROW0 + N_OUT;
  localparam int SP_ROW   = AR_ROW + 1;
  localparam int ROWS     = SP_ROW + 1;

  logic [ROWS-1:0][COLS-1:0] pat;
  logic [ROWS-1:0]           term;

  pla_cfg_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cmd_erase(cmd_erase), .cmd_lock(cmd_lock), .cmd_rewind(cmd_rewind),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_bit(ld_bit),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_bit(rb_bit),
    .pat(pat)
  );

  pla_and_plane #(.N_SIG(N_SIG), .ROWS(ROWS)) u_and (
    .sig({fb, din}), .pat(pat), .term(term)
  );

  pla_or_plane #(.N_OUT(N_OUT), .BASE_T(BASE_T), .STEP_T(STEP_T)) u_or (
    .term(term[SUM_ROWS-1:0]), .sum_out(sum_out)
  );

  assign oe_term = term[OE_ROW0 +: N_OUT];
  assign ar_term = term[AR_ROW];
  assign sp_term = term[SP_ROW];

  // Stored pattern of the reset row against the evaluated term.
  logic [N_SIG-1:0] ar_true, ar_comp;
  for (genvar s = 0; s < N_SIG; s++) begin : g_arlit
    assign ar_true[s] = pat[AR_ROW][2*s];
    assign ar_comp[s] = pat[AR_ROW][2*s + 1];
  end

  assert_conflict_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ar_true & ar_comp)) |-> !ar_term);

  for (genvar o = 0; o < N_OUT; o++) begin : g_oechk
    assert_empty_term_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pat[OE_ROW0 + o] == '0) |-> oe_term[o]);
  end

endmodule

// File: tb/test_pla_sop_array.sv
module test_pla_sop_array;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN  = 14;
  localparam int N_OUT = 12;
  localparam int N_SIG = N_IN + N_OUT;
  localparam int COLS  = 2 * N_SIG;

  function automatic int tb_count(int o);
    int k;
    k = (o < N_OUT / 2) ? o : N_OUT - 1 - o;
    return (k < 2) ? 8 : 8 + 2 * (k - 1);
  endfunction

  function automatic int tb_base(int o);
    int a;
    a = 0;
    for (int j = 0; j < o; j++) a += tb_count(j);
    return a;
  endfunction

  localparam int SUM_ROWS = 136;
  localparam int OE0  = SUM_ROWS;
  localparam int AR_R = OE0 + N_OUT;
  localparam int SP_R = AR_R + 1;
  localparam int ROWS = SP_R + 1;

  logic clk, rst_n;
  logic [N_IN-1:0]  din;
  logic [N_OUT-1:0] fb;
  logic [N_OUT-1:0] sum_out, oe_term;
  logic ar_term, sp_term;
  logic cmd_erase, cmd_lock, cmd_rewind;
  logic ld_valid, ld_ready, ld_bit;
  logic rb_valid, rb_ready, rb_bit;

  pla_sop_array i_pla_sop_array (
    .clk(clk), .rst_n(rst_n), .din(din), .fb(fb),
    .sum_out(sum_out), .oe_term(oe_term), .ar_term(ar_term), .sp_term(sp_term),
    .cmd_erase(cmd_erase), .cmd_lock(cmd_lock), .cmd_rewind(cmd_rewind),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_bit(ld_bit),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_bit(rb_bit)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [COLS-1:0] exp_pat [ROWS];
  logic [31:0] lf = 32'h1ACE_B00C;

  initial begin
    clk = 0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_term(int r, logic [N_SIG-1:0] sig);
    bit t;
    t = 1;
    for (int c = 0; c < COLS; c++)
      if (exp_pat[r][c]) begin
        if ((c % 2 == 0) && !sig[c/2]) t = 0;
        if ((c % 2 == 1) && sig[c/2]) t = 0;
      end
    return t;
  endfunction

  task automatic check_vec(input logic [N_IN-1:0] dv, input logic [N_OUT-1:0] fv,
                           input string req);
    logic [N_SIG-1:0] sig;
    logic [N_OUT-1:0] es, eo;
    @(negedge clk);
    din = dv;
    fb  = fv;
    #1;
    sig = {fv, dv};
    for (int o = 0; o < N_OUT; o++) begin
      es[o] = 0;
      for (int k = 0; k < tb_count(o); k++) es[o] |= model_term(tb_base(o) + k, sig);
      eo[o] = model_term(OE0 + o, sig);
    end
    check(sum_out === es, req, "sum_out (R4 R1)", 64'(sum_out), 64'(es));
    check(oe_term === eo, req, "oe_term (R5)", 64'(oe_term), 64'(eo));
    check(ar_term === model_term(AR_R, sig), req, "ar_term (R5 R3)",
          64'(ar_term), 64'(model_term(AR_R, sig)));
    check(sp_term === model_term(SP_R, sig), req, "sp_term (R5 R2)",
          64'(sp_term), 64'(model_term(SP_R, sig)));
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmd_erase = 1;
    if (which == 1) cmd_lock = 1;
    if (which == 2) cmd_rewind = 1;
    @(negedge clk);
    cmd_erase = 0; cmd_lock = 0; cmd_rewind = 0;
  endtask

  task automatic load_all(input bit gaps);
    int stalls;
    stalls = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        if (gaps && ((r + c) % 5 == 0)) begin
          ld_valid = 0;
          ld_bit = ~exp_pat[r][c];
          @(negedge clk);
        end
        ld_valid = 1;
        ld_bit = exp_pat[r][c];
        if (!ld_ready) stalls++;
      end
    @(negedge clk);
    ld_valid = 0;
    check(stalls == 0, "R6", "ld_ready low during load", 64'(stalls), 64'd0);
  endtask

  task automatic read_all(input string req, input bit blank);
    int cnt, bad, cyc;
    logic expb;
    cnt = 0; bad = 0; cyc = 0;
    while (cnt < ROWS * COLS && cyc < 3 * ROWS * COLS) begin
      @(negedge clk);
      cyc++;
      rb_ready = ((cyc % 3) != 0);
      if (rb_valid && rb_ready) begin
        expb = blank ? 1'b0 : exp_pat[cnt / COLS][cnt % COLS];
        if (rb_bit !== expb) bad++;
        cnt++;
      end
    end
    @(negedge clk);
    rb_ready = 0;
    check(bad == 0 && cnt == ROWS * COLS, req, "readback mismatches", 64'(bad), 64'd0);
    check(rb_valid === 1'b0, "R7", "rb_valid after full readback", 64'(rb_valid), 64'd0);
  endtask

  initial begin
    rst_n = 0; din = '0; fb = '0;
    cmd_erase = 0; cmd_lock = 0; cmd_rewind = 0;
    ld_valid = 0; ld_bit = 0; rb_ready = 0;
    for (int r = 0; r < ROWS; r++) exp_pat[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: reset state
    @(negedge clk);
    check(ld_ready === 1'b1, "R10", "ld_ready", 64'(ld_ready), 64'd1);
    check(rb_valid === 1'b1 && rb_bit === 1'b0, "R10", "rb_valid/rb_bit",
          {62'd0, rb_valid, rb_bit}, 64'd2);
    check_vec('0, '0, "R10");
    check_vec('1, '1, "R10");

    // Pattern A: four pseudo-chosen literals per row, empty and conflicting rows
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] v;
      v = '0;
      if (r % 7 != 0) begin
        v[(r * 5) % COLS] = 1;
        v[(r * 3 + 7) % COLS] = 1;
        v[(r * 17 + 11) % COLS] = 1;
        v[(r * 23 + 29) % COLS] = 1;
        if (r % 11 == 0) begin
          v[2 * ((r * 2) % N_SIG)] = 1;
          v[2 * ((r * 2) % N_SIG) + 1] = 1;
        end
      end
      exp_pat[r] = v;
    end
    load_all(1);
    check(ld_ready === 1'b0, "R6", "ld_ready after 150 rows", 64'(ld_ready), 64'd0);

    // R11 R1 R2 R3 R4 R5: pseudo-random vectors
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      check_vec(lf[N_IN-1:0], lf[N_IN+N_OUT-1:N_IN], "R11");
    end
    for (int s = 0; s < N_SIG; s++) begin
      logic [N_SIG-1:0] w;
      w = ~(N_SIG'(1) << s);
      check_vec(w[N_IN-1:0], w[N_SIG-1:N_IN], "R1");
    end

    // R7: readback with consumer back-pressure
    read_all("R7", 0);

    // R8: lock blanks readback, refuses loads, keeps the function
    pulse(2);
    pulse(1);
    check(ld_ready === 1'b0, "R8", "ld_ready while locked", 64'(ld_ready), 64'd0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      ld_valid = 1;
      ld_bit = 1;
    end
    @(negedge clk);
    ld_valid = 0;
    read_all("R8", 1);
    for (int i = 0; i < 50; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      check_vec(lf[N_IN-1:0], lf[N_IN+N_OUT-1:N_IN], "R8");
    end
    pulse(2);
    pulse(1);
    @(negedge clk);
    check(ld_ready === 1'b0 && rb_bit === 1'b0, "R9", "lock survives rewind",
          {62'd0, ld_ready, rb_bit}, 64'd0);

    // R9: erase together with lock: erase wins
    @(negedge clk);
    cmd_erase = 1;
    cmd_lock = 1;
    @(negedge clk);
    cmd_erase = 0;
    cmd_lock = 0;
    for (int r = 0; r < ROWS; r++) exp_pat[r] = '0;
    check(ld_ready === 1'b1 && rb_valid === 1'b1, "R9", "unlocked after erase",
          {62'd0, ld_ready, rb_valid}, 64'd3);
    check_vec(14'h2A5C, 12'h3C1, "R9");
    read_all("R9", 0);

    // R6: partial row abandoned by rewind
    pulse(2);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      ld_valid = 1;
      ld_bit = 1;
    end
    @(negedge clk);
    ld_valid = 0;
    pulse(2);

    // Pattern B: row r connects only the true literal of signal r mod 26
    for (int r = 0; r < ROWS; r++) begin
      exp_pat[r] = '0;
      exp_pat[r][2 * (r % N_SIG)] = 1;
    end
    load_all(0);
    check_vec('0, '0, "R4");
    for (int s = 0; s < N_SIG; s++) begin
      logic [N_SIG-1:0] w;
      w = N_SIG'(1) << s;
      check_vec(w[N_IN-1:0], w[N_SIG-1:N_IN], "R4");
    end
    pulse(2);
    read_all("R6", 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule